// File: doc/BRIEF.md
# Stereo Serial Audio Frame Emitter

This block sends pairs of 16-bit signed audio samples, one left and one right, over a three-wire serial link. The three wires are a bit clock, a word-select line and a data line. An upstream sample generator offers a new pair through a valid/ready handshake. A plain `sample_tick` pulse starts each frame. On every accepted tick the block latches the pair on offer and starts sending the pair it latched on the tick before. The generator can therefore compute the next sample while the current one is being shifted out.

A frame lasts `FRAME_LEN` bit-clock periods, and each period is `2*HALF_DIV` system clocks. The left word takes `SAMPLE_W` consecutive bit slots starting at slot `LEFT_AT`. The right word starts at slot `RIGHT_AT`. Each word goes out high byte first, and each byte goes out most significant bit first. Word select changes at two programmable slots, one inside each word. A build-time `INVERT` option complements the data line so that it can drive an external inverting buffer. Outside the two word windows, and between frames, the data line holds its last value and the bit clock rests low.

Back-pressure rule: `in_ready` is a single-cycle strobe, asserted only in the cycle a frame begins. The pair on `in_left`/`in_right` is taken only when `in_valid` is also high in that cycle. If `in_valid` is low then, the previously latched pair is kept and is sent again one frame later. The generator is never stalled. It only has to hold its data valid across the tick.

Top module: `stereo_frame_tx`

## Requirements
- R1: While `rst_n` is low and right after it rises, `bclk` is 0, `ws` is 1, `overrun` is 0 and `sdata` is 0 (1 when `INVERT` is set).
- R2: Within a frame, bit slot k carries bit (SAMPLE_W-1-(k-LEFT_AT)) of the left word for LEFT_AT <= k < LEFT_AT+SAMPLE_W, and bit (SAMPLE_W-1-(k-RIGHT_AT)) of the right word for RIGHT_AT <= k < RIGHT_AT+SAMPLE_W. The order is therefore left high byte, left low byte, right high byte, right low byte, each byte MSB first.
- R3: The frame started by an accepted tick carries the pair latched at the previous accepted tick. The first frame after reset carries zeros.
- R4: Each frame produces exactly FRAME_LEN bit-clock pulses, each HALF_DIV cycles low followed by HALF_DIV cycles high. `bclk` is low from the end of a frame until the next frame starts.
- R5: `sdata` changes only in the cycle where `bclk` goes low or a frame starts. It never changes while `bclk` stays high.
- R6: `ws` is 1 from reset and between frames. It goes to 0 as slot WS_FALL_AT begins and back to 1 as slot WS_RISE_AT begins, with each change coinciding with a falling bit-clock edge.
- R7: With `INVERT` set, `sdata` is the bitwise complement of the line produced with `INVERT` clear, in every bit slot.
- R8: `in_ready` is high only in a cycle where `sample_tick` is high and the block is free. The input pair is latched only when `in_valid` and `in_ready` are both high. Otherwise the pending pair is kept.
- R9: A `sample_tick` that arrives while a frame is still running (other than its last cycle) is ignored: no pair is latched and the running frame is unchanged. It also sets `overrun`, which stays 1 until reset.
- R10: A tick in the last cycle of a frame, exactly FRAME_LEN*2*HALF_DIV cycles after the previous accepted tick, is accepted. The new frame follows with no gap, and `overrun` is not set.
- R11: In slots outside both word windows and between frames, `sdata` holds the last bit sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Frame start request, one cycle |
| in_valid | input | 1 | Sample pair on offer |
| in_ready | output | 1 | Pair accepted / frame begins (one-cycle strobe) |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select |
| sdata | output | 1 | Serial data, optionally inverted |
| overrun | output | 1 | Sticky flag: tick arrived during a frame |

## Verification
Two events can land in the same clock cycle: the final half-period of a running frame closing out, and a new tick asking for the next frame to start. The bench walks its vector table with ticks spaced exactly one frame length apart, so every start falls in the closing cycle of the previous frame. It judges the outcome by the pulse count and bit content of each captured frame and by `overrun` staying low. A second collision places a tick in the middle of a frame. There the bench expects `in_ready` low, the frame undisturbed, the offered pair never appearing on the line, and the overrun flag set and kept.

// File: rtl/stereo_frame_pkg.sv
package stereo_frame_pkg;

  localparam int SAMPLE_W = 16;

  typedef struct packed {
    logic [SAMPLE_W-1:0] left;
    logic [SAMPLE_W-1:0] right;
  } stereo_pair_t;

endpackage

// File: rtl/emit_timer.sv
module emit_timer #(
  parameter int HALF_DIV  = 2,
  parameter int FRAME_LEN = 96,
  localparam int SLOT_W   = $clog2(FRAME_LEN),
  localparam int DIV_W    = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              bclk,
  output logic              adv,
  output logic              last_edge,
  output logic [SLOT_W-1:0] next_slot
);

  logic              busy_q;
  logic              hi_q;
  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_q;
  logic              half_end;

  assign half_end  = busy_q && (div_q == DIV_W'(HALF_DIV - 1));
  assign last_edge = half_end && hi_q && (slot_q == SLOT_W'(FRAME_LEN - 1));
  assign adv       = start || (half_end && hi_q && !last_edge);
  assign next_slot = start ? '0 : slot_q + SLOT_W'(1);
  assign busy      = busy_q;
  assign bclk      = hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      div_q  <= '0;
      slot_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      hi_q   <= 1'b0;
      div_q  <= '0;
      slot_q <= '0;
    end else if (busy_q) begin
      if (half_end) begin
        div_q <= '0;
        if (!hi_q) begin
          hi_q <= 1'b1;
        end else if (last_edge) begin
          hi_q   <= 1'b0;
          busy_q <= 1'b0;
        end else begin
          hi_q   <= 1'b0;
          slot_q <= slot_q + SLOT_W'(1);
        end
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/emit_shifter.sv
module emit_shifter
  import stereo_frame_pkg::*;
#(
  parameter int FRAME_LEN = 96,
  parameter int LEFT_AT   = 36,
  parameter int RIGHT_AT  = 73,
  parameter bit INVERT    = 1'b0,
  localparam int SLOT_W   = $clog2(FRAME_LEN),
  localparam int IDX_W    = $clog2(SAMPLE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [SLOT_W-1:0] next_slot,
  input  stereo_pair_t      word,
  output logic              sdata
);

  logic raw_q;
  logic bit_d;
  int   off_l;
  int   off_r;
  logic [IDX_W-1:0] idx_l;
  logic [IDX_W-1:0] idx_r;

  always_comb begin
    off_l = int'(next_slot) - LEFT_AT;
    off_r = int'(next_slot) - RIGHT_AT;
    idx_l = IDX_W'(SAMPLE_W - 1 - off_l);
    idx_r = IDX_W'(SAMPLE_W - 1 - off_r);
    bit_d = raw_q;
    if (off_l >= 0 && off_l < SAMPLE_W) begin
      bit_d = word.left[idx_l];
    end else if (off_r >= 0 && off_r < SAMPLE_W) begin
      bit_d = word.right[idx_r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b0;
    else if (adv) raw_q <= bit_d;
  end

  generate
    if (INVERT) begin : g_inv
      assign sdata = ~raw_q;
    end else begin : g_true
      assign sdata = raw_q;
    end
  endgenerate

endmodule

// File: rtl/emit_wsgen.sv
module emit_wsgen #(
  parameter int FRAME_LEN  = 96,
  parameter int WS_FALL_AT = 44,
  parameter int WS_RISE_AT = 81,
  localparam int SLOT_W    = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [SLOT_W-1:0] next_slot,
  output logic              ws
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws <= 1'b1;
    end else if (adv) begin
      if (next_slot == SLOT_W'(WS_FALL_AT)) ws <= 1'b0;
      else if (next_slot == SLOT_W'(WS_RISE_AT)) ws <= 1'b1;
    end
  end

endmodule

// File: rtl/stereo_frame_tx.sv
module stereo_frame_tx
  import stereo_frame_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int FRAME_LEN  = 96,
  parameter int LEFT_AT    = 36,
  parameter int RIGHT_AT   = 73,
  parameter int WS_FALL_AT = 44,
  parameter int WS_RISE_AT = 81,
  parameter bit INVERT     = 1'b0,
  localparam int SLOT_W    = $clog2(FRAME_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_tick,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                bclk,
  output logic                ws,
  output logic                sdata,
  output logic                overrun
);

  logic              busy;
  logic              adv;
  logic              last_edge;
  logic              free;
  logic              start;
  logic [SLOT_W-1:0] next_slot;
  stereo_pair_t      pend_q;
  stereo_pair_t      send_q;
  stereo_pair_t      cur_word;
  logic              overrun_q;

  assign free     = !busy || last_edge;
  assign start    = sample_tick && free;
  assign in_ready = start;
  assign cur_word = start ? pend_q : send_q;
  assign overrun  = overrun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      send_q    <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (start) send_q <= pend_q;
      if (start && in_valid) pend_q <= '{left: in_left, right: in_right};
      if (sample_tick && !free) overrun_q <= 1'b1;
    end
  end

  emit_timer #(
    .HALF_DIV (HALF_DIV),
    .FRAME_LEN(FRAME_LEN)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .bclk     (bclk),
    .adv      (adv),
    .last_edge(last_edge),
    .next_slot(next_slot)
  );

  emit_shifter #(
    .FRAME_LEN(FRAME_LEN),
    .LEFT_AT  (LEFT_AT),
    .RIGHT_AT (RIGHT_AT),
    .INVERT   (INVERT)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .next_slot(next_slot),
    .word     (cur_word),
    .sdata    (sdata)
  );

  emit_wsgen #(
    .FRAME_LEN (FRAME_LEN),
    .WS_FALL_AT(WS_FALL_AT),
    .WS_RISE_AT(WS_RISE_AT)
  ) u_ws (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .next_slot(next_slot),
    .ws       (ws)
  );

endmodule

// File: rtl/stereo_frame_tx_checker.sv
module stereo_frame_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic sample_tick,
  input logic in_ready,
  input logic bclk,
  input logic ws,
  input logic sdata,
  input logic overrun
);

  // R8: ready strobes only together with a tick
  assert_ready_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> sample_tick);

  // R5: data does not move while the bit clock stays high
  assert_sdata_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk && $past(bclk)) |-> $stable(sdata));

  // R6: word select only moves with the bit clock low afterwards
  assert_ws_moves_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> !bclk);

  // R9: a refused tick raises overrun next cycle
  assert_refused_tick_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !in_ready) |=> overrun);

  // R9: overrun is sticky
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R4: each frame opens with the bit clock low
  assert_frame_opens_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !bclk);

endmodule

bind stereo_frame_tx stereo_frame_tx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_tick(sample_tick),
  .in_ready   (in_ready),
  .bclk       (bclk),
  .ws         (ws),
  .sdata      (sdata),
  .overrun    (overrun)
);

// File: tb/stereo_frame_tx_test.sv
module stereo_frame_tx_test;

  localparam int HALF   = 2;
  localparam int FLEN   = 96;
  localparam int L_AT   = 36;
  localparam int R_AT   = 73;
  localparam int WS_F   = 44;
  localparam int WS_R   = 81;
  localparam int NCYC   = FLEN * 2 * HALF;
  localparam int NVEC   = 6;

  // {valid, left, right}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 16'h8001, 16'h7FFE},
    {1'b1, 16'h1234, 16'hABCD},
    {1'b0, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'h0000, 16'hFFFF},
    {1'b1, 16'hA55A, 16'h5AA5},
    {1'b1, 16'h00FF, 16'hFF00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_left = '0;
  logic [15:0] in_right = '0;
  logic in_ready, bclk, ws, sdata, overrun;
  logic in_ready_i, bclk_i, ws_i, sdata_i, overrun_i;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  stereo_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .bclk(bclk), .ws(ws), .sdata(sdata), .overrun(overrun)
  );

  stereo_frame_tx #(.INVERT(1'b1)) uut_inv (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .in_valid(in_valid),
    .in_ready(in_ready_i), .in_left(in_left), .in_right(in_right),
    .bclk(bclk_i), .ws(ws_i), .sdata(sdata_i), .overrun(overrun_i)
  );

  // capture at bit-clock rising edges
  logic cap_bit [FLEN];
  logic cap_ws  [FLEN];
  logic cap_inv [FLEN];
  int   cap_n = 0;
  int   stable_bad = 0;
  logic prev_bclk = 1'b0;
  logic last_rise_bit = 1'b0;

  always @(negedge clk) begin
    if (bclk && !prev_bclk) begin
      if (cap_n < FLEN) begin
        cap_bit[cap_n] = sdata;
        cap_ws[cap_n]  = ws;
        cap_inv[cap_n] = sdata_i;
      end
      cap_n = cap_n + 1;
      last_rise_bit = sdata;
    end else if (bclk && prev_bclk && sdata !== last_rise_bit) begin
      stable_bad = stable_bad + 1;
    end
    prev_bclk = bclk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench model of the pipeline (R3, R8)
  logic [31:0] pend_m = '0;
  logic [31:0] sent_m = '0;
  logic        hold_m = 1'b0;

  // caller sits at a negedge; returns at the negedge before the next allowed start
  task automatic run_frame(input logic v, input logic [15:0] l, input logic [15:0] r,
                           input bit mid_tick);
    int bad_bits = 0;
    int bad_ws = 0;
    int bad_inv = 0;
    logic e;
    in_valid = v; in_left = l; in_right = r; sample_tick = 1'b1;
    #0.1;
    check(in_ready === 1'b1, "R8", "ready at free tick", {31'd0, in_ready}, 32'd1);
    sent_m = pend_m;
    if (v) pend_m = {l, r};
    cap_n = 0;
    @(negedge clk);
    sample_tick = 1'b0; in_valid = 1'b0;
    for (int c = 1; c < NCYC; c++) begin
      if (mid_tick && c == 100) begin
        sample_tick = 1'b1; in_valid = 1'b1; in_left = 16'hDEAD; in_right = 16'hBEEF;
        #0.1;
        check(in_ready === 1'b0, "R9", "ready during busy tick", {31'd0, in_ready}, 32'd0);
      end
      @(negedge clk);
      sample_tick = 1'b0; in_valid = 1'b0;
      if (mid_tick && c == 100)
        check(overrun === 1'b1, "R9", "overrun after busy tick", {31'd0, overrun}, 32'd1);
    end
    check(cap_n == FLEN, "R4", "bclk pulses per frame", cap_n, FLEN);
    e = hold_m;
    for (int k = 0; k < FLEN; k++) begin
      if (k >= L_AT && k < L_AT + 16) e = sent_m[31 - (k - L_AT)];
      else if (k >= R_AT && k < R_AT + 16) e = sent_m[15 - (k - R_AT)];
      if (cap_bit[k] !== e) bad_bits++;
      if (cap_ws[k] !== ((k >= WS_F && k < WS_R) ? 1'b0 : 1'b1)) bad_ws++;
      if (cap_inv[k] !== ~cap_bit[k]) bad_inv++;
    end
    hold_m = sent_m[0];
    check(bad_bits == 0, "R2/R3/R11", "bit slots mismatched", bad_bits, 0);
    check(bad_ws == 0, "R6", "ws slots mismatched", bad_ws, 0);
    check(bad_inv == 0, "R7", "inverted slots mismatched", bad_inv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(bclk === 1'b0 && ws === 1'b1 && sdata === 1'b0 && overrun === 1'b0,
          "R1", "reset outputs", {28'd0, bclk, ws, sdata, overrun}, 32'h4);
    check(sdata_i === 1'b1, "R1", "reset sdata inverted", {31'd0, sdata_i}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(bclk === 1'b0 && ws === 1'b1 && overrun === 1'b0, "R1", "after reset release",
          {29'd0, bclk, ws, overrun}, 32'h2);

    // vector table, ticks back to back exactly one frame apart (R10)
    for (int i = 0; i < NVEC; i++) begin
      run_frame(VEC[i][32], VEC[i][31:16], VEC[i][15:0], 1'b0);
    end
    check(overrun === 1'b0, "R10", "back-to-back ticks not flagged", {31'd0, overrun}, 32'd0);
    check(stable_bad == 0, "R5", "sdata moved while bclk high", stable_bad, 0);

    // idle between frames (R4, R11)
    begin
      int idle_bad = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (bclk !== 1'b0 || sdata !== hold_m || ws !== 1'b1) idle_bad++;
      end
      check(idle_bad == 0, "R4/R11", "idle line state", idle_bad, 0);
    end

    // tick during a frame (R9), then show the offered pair was not latched
    run_frame(1'b1, 16'h7F80, 16'h0102, 1'b1);
    run_frame(1'b0, 16'h0000, 16'h0000, 1'b0);
    check(sent_m == 32'h7F800102, "R9", "ignored tick pair not latched", sent_m, 32'h7F800102);
    check(overrun === 1'b1, "R9", "overrun sticky", {31'd0, overrun}, 32'd1);
    check(stable_bad == 0, "R5", "sdata moved while bclk high", stable_bad, 0);

    // reset in the middle of a frame
    in_valid = 1'b1; in_left = 16'hFFFF; in_right = 16'hFFFF; sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0; in_valid = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(bclk === 1'b0 && ws === 1'b1 && sdata === 1'b0 && overrun === 1'b0,
          "R1", "mid-frame reset", {28'd0, bclk, ws, sdata, overrun}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    pend_m = '0; sent_m = '0; hold_m = 1'b0;
    run_frame(1'b1, 16'h4321, 16'h8765, 1'b0);
    check(sent_m == 32'h0, "R3", "first frame after reset is zero", sent_m, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule